// File: doc/BRIEF.md
# Keyboard-Controller Output Port with Reset Pulse and A20 Gate

This block holds the 8-bit parallel output port of a keyboard controller. It stores the port byte, drives the A20 gate line from port bit 1 and raises a one-cycle CPU reset request whenever port bit 0 enters a low phase. A command decoder upstream hands it decoded command bytes and full-port write strobes. The block does not decode the host bus.

The pulse family of commands (upper nibble 0xF) drives selected low bits of the port low for a fixed number of clock cycles. A cleared bit in the command's low nibble selects a bit for pulsing, and a set bit leaves that bit alone. Code 0xFE therefore resets the CPU, and 0xFF does nothing. When the pulse ends, the shown bits return to the held value. Two dedicated commands set and clear the A20 gate. The two buffer-full flags of the controller show through on bits 4 and 5 of the port value.

Top module: `outport_ctl`

## Requirements
- R1: After reset the port value is 0xCF (bit 0 reset-inactive high, bit 1 A20 high, constant ones on bits 2, 3, 6 and 7), a20_gate is 1 and reset_req is 0.
- R2: Port bit 4 always equals kbd_full and port bit 5 always equals aux_full, in the same cycle, whatever has been written.
- R3: A full-port write (port_wr) stores port_wdata. From the next cycle, bits 7:6 and 3:0 show the written byte, and a20_gate follows written bit 1.
- R4: A full-port write with bit 0 equal to 0 raises reset_req for exactly the next cycle. Bit 0 then stays low until it is written again.
- R5: Command code 0xDF sets bit 1 and a20_gate, and code 0xDD clears both. The other bits are unchanged.
- R6: A command with code 0xF0 to 0xFE drives low each of bits 3:0 whose code bit is 0, for PULSE_CYCLES cycles starting in the next cycle. The shown bits, and a20_gate for bit 1, then return to the held values.
- R7: A pulse command with code bit 0 equal to 0 raises reset_req for exactly the first cycle of the pulse.
- R8: Code 0xFF and codes outside the A20 and pulse commands change nothing, and they raise no reset_req.
- R9: A pulse command that arrives while a pulse is active is ignored. It neither restarts nor extends the pulse and raises no reset_req.
- R10: A full-port write or an A20 command during a pulse updates the held byte. The pulsed bits stay low until the pulse ends and then show the new held value.
- R11: When port_wr and an A20 command fall in the same cycle, the written byte wins. When port_wr and a pulse command fall in the same cycle, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoded command byte valid this cycle |
| cmd_code | input | 8 | Decoded command byte |
| port_wr | input | 1 | Full-port write strobe |
| port_wdata | input | 8 | Byte for the full-port write |
| kbd_full | input | 1 | Keyboard output buffer full flag |
| aux_full | input | 1 | Mouse output buffer full flag |
| port_val | output | 8 | Current output port value including pulses and flags |
| a20_gate | output | 1 | A20 gate line |
| reset_req | output | 1 | One-cycle CPU reset request |

## Verification
A held-byte update and an active pulse can meet in the same cycle. A write or an A20 command lands while bits are pulsed low, so the shown value must keep the pulsed bits low and only take on the new held value when the pulse ends. The bench issues 0xDD and a full-port write mid-pulse, then compares the port every cycle against a model that keeps the held byte and the pulse mask apart. It also fires a full-port write in the same cycle as an A20 command, and in the same cycle as a pulse command with bit 0 selected. In these cases it judges the winner of the held byte and the single reset strobe.

// File: rtl/outport_pkg.sv
package outport_pkg;
  localparam logic [7:0] OP_RESET_VAL = 8'hCF;
  localparam logic [7:0] CMD_A20_ON   = 8'hDF;
  localparam logic [7:0] CMD_A20_OFF  = 8'hDD;
  localparam logic [3:0] PULSE_NIB    = 4'hF;
  localparam int         BIT_RST      = 0;
  localparam int         BIT_A20      = 1;

  function automatic logic is_pulse_cmd(input logic [7:0] code);
    return code[7:4] == PULSE_NIB;
  endfunction
endpackage

// File: rtl/outport_hold.sv
module outport_hold
  import outport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       a20_on,
  input  logic       a20_off,
  output logic [7:0] held_q
);
  logic [7:0] held_d;
  logic       upd_en;

  assign upd_en = wr_en | a20_on | a20_off;

  // a full write takes precedence over the A20 commands
  always_comb begin
    held_d = held_q;
    if (wr_en)        held_d = wr_data;
    else if (a20_on)  held_d[BIT_A20] = 1'b1;
    else if (a20_off) held_d[BIT_A20] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= OP_RESET_VAL;
    else if (upd_en) held_q <= held_d;
  end
endmodule

// File: rtl/outport_pulse.sv
module outport_pulse #(
  parameter int PULSE_CYCLES = 300,
  parameter int CNT_W        = $clog2(PULSE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       req_keep,
  output logic             start,
  output logic [3:0]       low_mask,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic [3:0]       mask_q, mask_d;
  logic [CNT_W-1:0] cnt_d;
  logic             busy;

  assign busy     = (mask_q != 4'h0);
  assign start    = req_valid && (req_keep != 4'hF) && !busy;
  assign low_mask = mask_q;

  always_comb begin
    mask_d = mask_q;
    cnt_d  = cnt_q;
    if (start) begin
      mask_d = ~req_keep;
      cnt_d  = LOAD;
    end else if (busy) begin
      if (cnt_q == '0) mask_d = 4'h0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 4'h0;
      cnt_q  <= '0;
    end else if (start || busy) begin
      mask_q <= mask_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/outport_ctl.sv
module outport_ctl
  import outport_pkg::*;
#(
  parameter int PULSE_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       port_wr,
  input  logic [7:0] port_wdata,
  input  logic       kbd_full,
  input  logic       aux_full,
  output logic [7:0] port_val,
  output logic       a20_gate,
  output logic       reset_req
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  logic [7:0]       held_q;
  logic [3:0]       low_mask;
  logic [CNT_W-1:0] pulse_cnt;
  logic             pulse_start;
  logic             a20_on, a20_off, pulse_req;
  logic             strobe_d, strobe_q;

  assign a20_on    = cmd_valid && (cmd_code == CMD_A20_ON);
  assign a20_off   = cmd_valid && (cmd_code == CMD_A20_OFF);
  assign pulse_req = cmd_valid && is_pulse_cmd(cmd_code);

  outport_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (port_wr),
    .wr_data (port_wdata),
    .a20_on  (a20_on),
    .a20_off (a20_off),
    .held_q  (held_q)
  );

  outport_pulse #(.PULSE_CYCLES(PULSE_CYCLES), .CNT_W(CNT_W)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (pulse_req),
    .req_keep  (cmd_code[3:0]),
    .start     (pulse_start),
    .low_mask  (low_mask),
    .cnt_q     (pulse_cnt)
  );

  // a reset request accompanies every entry of bit 0 into a low phase
  assign strobe_d = (port_wr && !port_wdata[BIT_RST]) ||
                    (pulse_start && !cmd_code[BIT_RST]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  assign reset_req = strobe_q;
  assign port_val  = {held_q[7:6], aux_full, kbd_full, held_q[3:0] & ~low_mask};
  assign a20_gate  = held_q[BIT_A20] & ~low_mask[BIT_A20];
endmodule

// File: rtl/outport_ctl_chk.sv
module outport_ctl_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [7:0]       cmd_code,
  input logic             port_wr,
  input logic [7:0]       port_wdata,
  input logic [7:0]       port_val,
  input logic             a20_gate,
  input logic             reset_req,
  input logic [7:0]       held_q,
  input logic [3:0]       low_mask,
  input logic [CNT_W-1:0] pulse_cnt
);
  assert_hold_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> held_q == $past(port_wdata));

  assert_wr_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr && !port_wdata[0] |=> reset_req);

  assert_a20_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 8'hDF && !port_wr && low_mask == 4'h0 |=> a20_gate);

  assert_a20_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 8'hDD && !port_wr |=> !a20_gate);

  assert_pulse_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code[7:4] == 4'hF && low_mask == 4'h0
    |=> (port_val[3:0] & ~$past(cmd_code[3:0])) == 4'h0);

  assert_pulse_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code[7:4] == 4'hF && !cmd_code[0] && low_mask == 4'h0
    |=> reset_req && !port_val[0]);

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    low_mask != 4'h0 && pulse_cnt != '0 |=> $stable(low_mask));
endmodule

bind outport_ctl outport_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .port_wr    (port_wr),
  .port_wdata (port_wdata),
  .port_val   (port_val),
  .a20_gate   (a20_gate),
  .reset_req  (reset_req),
  .held_q     (held_q),
  .low_mask   (low_mask),
  .pulse_cnt  (pulse_cnt)
);

// File: tb/tb_outport_ctl.sv
`timescale 1ns/1ps
module tb_outport_ctl;
  localparam int P = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_code;
  logic       port_wr;
  logic [7:0] port_wdata;
  logic       kbd_full, aux_full;
  logic [7:0] port_val;
  logic       a20_gate, reset_req;

  always #10 clk = ~clk;

  outport_ctl #(.PULSE_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .port_wr(port_wr), .port_wdata(port_wdata), .kbd_full(kbd_full),
    .aux_full(aux_full), .port_val(port_val), .a20_gate(a20_gate),
    .reset_req(reset_req)
  );

  int    n_vec = 0, n_bad = 0, cyc = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference: held byte, active-low mask, cycles left, strobe
  logic [7:0] m_held;
  logic [3:0] m_mask;
  int         m_left;
  bit         m_strb;

  task automatic model_reset();
    m_held = 8'hCF; m_mask = 4'h0; m_left = 0; m_strb = 0;
  endtask

  task automatic compare();
    logic [7:0] e_port;
    logic       e_a20;
    e_port = {m_held[7:6], aux_full, kbd_full, m_held[3:0] & ~m_mask};
    e_a20  = m_held[1] & ~m_mask[1];
    n_vec++;
    if (port_val !== e_port || a20_gate !== e_a20 || reset_req !== m_strb) begin
      n_bad++;
      $display("FAIL %s: port %h exp %h, a20 %b exp %b, reset_req %b exp %b",
               tag, port_val, e_port, a20_gate, e_a20, reset_req, m_strb);
    end
  endtask

  task automatic step(input bit cv, input [7:0] c, input bit w, input [7:0] d);
    bit         busy, start;
    logic [7:0] n_held;
    logic [3:0] n_mask;
    int         n_left;
    cmd_valid = cv; cmd_code = c; port_wr = w; port_wdata = d;
    busy  = (m_mask != 0);
    start = cv && c[7:4] == 4'hF && c[3:0] != 4'hF && !busy;
    n_held = m_held;
    if (w) n_held = d;
    else if (cv && c == 8'hDF) n_held[1] = 1'b1;
    else if (cv && c == 8'hDD) n_held[1] = 1'b0;
    n_mask = m_mask; n_left = m_left;
    if (start) begin n_mask = ~c[3:0]; n_left = P - 1; end
    else if (busy) begin
      if (m_left == 0) n_mask = 4'h0; else n_left = m_left - 1;
    end
    @(posedge clk); #2;
    m_strb = (w && !d[0]) || (start && !c[0]);
    m_held = n_held; m_mask = n_mask; m_left = n_left;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 8'h00);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: cycle %0d exp completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_code = 0; port_wr = 0; port_wdata = 0;
    kbd_full = 0; aux_full = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #2; tag = "R1"; compare();              // R1 reset value 0xCF
    rst_n = 1;
    idle(2);
    // R2 flag mirroring
    tag = "R2";
    kbd_full = 1; #1 compare();
    aux_full = 1; #1 compare();
    kbd_full = 0; #1 compare();
    step(0, 8'h00, 1, 8'hFF); aux_full = 0; #1 compare();
    // R3 full write, A20 low
    tag = "R3";
    step(0, 8'h00, 1, 8'hA5); idle(2);
    step(0, 8'h00, 1, 8'h7F); idle(1);
    // R4 write with bit 0 low
    tag = "R4";
    step(0, 8'h00, 1, 8'h5A); idle(3);
    step(0, 8'h00, 1, 8'hCF); idle(1);
    // R5 A20 commands
    tag = "R5";
    step(1, 8'hDD, 0, 8'h00); idle(1);
    step(1, 8'hDD, 0, 8'h00);
    step(1, 8'hDF, 0, 8'h00); idle(1);
    // R6 pulses of several masks
    tag = "R6";
    step(1, 8'hFD, 0, 8'h00); idle(P + 2);
    step(1, 8'hF3, 0, 8'h00); idle(P + 2);
    step(1, 8'hF5, 0, 8'h00); idle(P + 2);
    // R7 pulse on bit 0
    tag = "R7";
    step(1, 8'hFE, 0, 8'h00); idle(P + 2);
    step(1, 8'hF0, 0, 8'h00); idle(P + 2);
    // R8 no-effect codes
    tag = "R8";
    step(1, 8'hFF, 0, 8'h00); idle(1);
    step(1, 8'h20, 0, 8'h00);
    step(1, 8'hDE, 0, 8'h00);
    step(1, 8'hEF, 0, 8'h00); idle(2);
    // R9 pulse during pulse ignored
    tag = "R9";
    step(1, 8'hFB, 0, 8'h00); idle(3);
    step(1, 8'hF0, 0, 8'h00); idle(2);
    step(1, 8'hFE, 0, 8'h00); idle(P);
    // R10 held updates during a pulse
    tag = "R10";
    step(1, 8'hF0, 0, 8'h00); idle(2);
    step(1, 8'hDD, 0, 8'h00); idle(2);
    step(0, 8'h00, 1, 8'h3B); idle(P);
    step(0, 8'h00, 1, 8'hCF); idle(1);
    // R11 same-cycle write and command
    tag = "R11";
    step(1, 8'hDF, 1, 8'hC5); idle(1);
    step(1, 8'hDD, 1, 8'hCF); idle(1);
    step(1, 8'hFE, 1, 8'h4C); idle(P + 2);
    step(1, 8'hFC, 1, 8'hCF); idle(P + 2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule